// File: doc/BRIEF.md
# Register-Cached Parameter Stack Datapath

This block holds the data stack of a small stack-oriented processor. The two uppermost cells sit in registers, exposed as `tos` (top of stack) and `nos` (next on stack), so an external ALU can read both operands with no memory latency. The third and deeper cells spill into a private stack memory of `DEPTH` words, addressed by a pointer that counts the cells held there. Each decoded operation applies a fixed shuffle between the two registers and the memory.

The instruction decoder presents one operation per cycle on `op_code`, qualified by `op_valid`. Short literals arrive on `lit5`, long literals on `lit_word`, and ALU results on `alu_result`. The datapath accepts an operation on every cycle in which `op_valid` is high. It never applies back-pressure, so it has no ready output. The whole effect of an accepted operation is visible after the next rising clock edge. Spilling beyond the memory's capacity, or filling from an empty memory, raises a sticky error flag that stays set until reset.

Top module: `stk_param_stack`

## Requirements
- R1: A synchronous reset clears `tos`, `nos`, `sp`, `ovf` and `unf` to zero.
- R2: Code 1 (exchange) swaps `tos` and `nos`. `sp` is unchanged.
- R3: Code 2 (duplicate) copies `tos` into `nos` and pushes the old `nos` into the stack memory. `tos` is unchanged.
- R4: Code 3 (over) loads the old `nos` into `tos` and the old `tos` into `nos`, and pushes the old `nos` into memory.
- R5: Code 4 (discard) loads the old `nos` into `tos` and refills `nos` from the most recently pushed memory cell (last in, first out). `sp` decrements.
- R6: Code 5 (short literal) loads `lit5`, zero-extended, into `tos`. The old `tos` moves to `nos` and the old `nos` is pushed.
- R7: Code 6 (long literal) does the same shuffle as R6, with the full `lit_word` as the new `tos`.
- R8: When `op_inv` is high with any code from 0 to 8, the final `tos` is the ones complement of the value the code alone would produce. Code 0 with `op_inv` low changes nothing.
- R9: Codes 9 to 15 are reserved. They leave `tos`, `nos`, `sp` and the memory unchanged, whatever the value of `op_inv`.
- R10: Code 7 loads `alu_result` into `tos` and leaves `nos` and `sp` unchanged. Code 8 loads `alu_result` into `tos` and refills `nos` from memory, as R5 does.
- R11: A push while `sp == DEPTH` sets `ovf`, which then stays set. The memory write and the pointer increment are suppressed, and the register shuffle still happens, so the old `nos` is lost.
- R12: A pop while `sp == 0` sets `unf`, which then stays set. `nos` is loaded with zero and `sp` stays 0.
- R13: While `op_valid` is low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 4 | Decoded stack operation (see R2 to R10) |
| op_inv | input | 1 | Complement the resulting `tos` |
| lit5 | input | 5 | Short literal, 0 to 31 |
| lit_word | input | WIDTH | Long literal word |
| alu_result | input | WIDTH | Result from the external ALU |
| tos | output | WIDTH | Top-of-stack register |
| nos | output | WIDTH | Second stack register |
| sp | output | $clog2(DEPTH+1) | Number of cells held in stack memory |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The main function is driven with long random streams over all sixteen codes, random `op_inv`, literals and ALU results, with `op_valid` sometimes low. This mixes pushes, pops and neutral operations, so that data written many cycles earlier has to come back in last-in, first-out order. Directed runs drive more than `DEPTH` pushes back to back and pops from an empty memory. These separate a correct full or empty boundary from an off-by-one pointer, and show that the suppressed write does not corrupt the cell at the limit. Runs of reserved codes with `op_inv` set show that the complement is not applied on its own when the code is reserved.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_SWAP   = 4'd1,
    OP_DUP    = 4'd2,
    OP_OVER   = 4'd3,
    OP_DROP   = 4'd4,
    OP_LITS   = 4'd5,
    OP_LITL   = 4'd6,
    OP_ALU    = 4'd7,
    OP_ALUPOP = 4'd8
  } stk_op_e;

  localparam logic [3:0] OP_LAST_DEFINED = 4'd8;

  function automatic logic op_pushes(input logic [3:0] c);
    return (c == OP_DUP) || (c == OP_OVER) || (c == OP_LITS) || (c == OP_LITL);
  endfunction

  function automatic logic op_pops(input logic [3:0] c);
    return (c == OP_DROP) || (c == OP_ALUPOP);
  endfunction
endpackage

// File: rtl/stk_spill_mem.sv
module stk_spill_mem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [WIDTH-1:0] mem_rd_data,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [AW-1:0]    mem_rd_addr,
  output logic [WIDTH-1:0] fill_data,
  output logic [PW-1:0]    sp,
  output logic             ovf,
  output logic             unf
);
  logic [PW-1:0] sp_q;
  logic          ovf_q, unf_q;
  logic          full, empty;

  assign full        = (sp_q == PW'(DEPTH));
  assign empty       = (sp_q == '0);
  assign mem_wr_en   = push_req && !full;
  assign mem_wr_addr = sp_q[AW-1:0];
  assign mem_rd_addr = AW'(sp_q - PW'(1));
  assign fill_data   = empty ? '0 : mem_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (push_req) begin
        if (full) ovf_q <= 1'b1;
        else      sp_q  <= sp_q + PW'(1);
      end else if (pop_req) begin
        if (empty) unf_q <= 1'b1;
        else       sp_q  <= sp_q - PW'(1);
      end
    end
  end

  assign sp  = sp_q;
  assign ovf = ovf_q;
  assign unf = unf_q;

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst) sp_q <= PW'(DEPTH));
  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst) (push_req && full) |=> ovf_q && $stable(sp_q));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf_q |=> ovf_q);
  // R12
  unf_set_chk: assert property (@(posedge clk) disable iff (rst) (pop_req && empty) |=> unf_q && sp_q == '0);
  // R12
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst) unf_q |=> unf_q);
  // R5
  pop_move_chk: assert property (@(posedge clk) disable iff (rst) (pop_req && !empty) |=> sp_q == $past(sp_q) - PW'(1));
endmodule

// File: rtl/stk_reg_shuffle.sv
module stk_reg_shuffle
  import stk_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             op_inv,
  input  logic [4:0]       lit5,
  input  logic [WIDTH-1:0] lit_word,
  input  logic [WIDTH-1:0] alu_result,
  input  logic [WIDTH-1:0] fill_data,
  output logic             push_req,
  output logic             pop_req,
  output logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] tos,
  output logic [WIDTH-1:0] nos
);
  logic [WIDTH-1:0] tos_q, nos_q, tos_raw, nos_d;
  logic             defined;

  assign defined   = op_valid && (op_code <= OP_LAST_DEFINED);
  assign push_req  = defined && op_pushes(op_code);
  assign pop_req   = defined && op_pops(op_code);
  assign push_data = nos_q;

  always_comb begin
    tos_raw = tos_q;
    nos_d   = nos_q;
    case (op_code)
      OP_SWAP:   begin tos_raw = nos_q;                nos_d = tos_q;     end
      OP_DUP:    begin                                 nos_d = tos_q;     end
      OP_OVER:   begin tos_raw = nos_q;                nos_d = tos_q;     end
      OP_DROP:   begin tos_raw = nos_q;                nos_d = fill_data; end
      OP_LITS:   begin tos_raw = WIDTH'(lit5);         nos_d = tos_q;     end
      OP_LITL:   begin tos_raw = lit_word;             nos_d = tos_q;     end
      OP_ALU:    begin tos_raw = alu_result;                              end
      OP_ALUPOP: begin tos_raw = alu_result;           nos_d = fill_data; end
      default:   begin                                                    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      nos_q <= '0;
    end else if (defined) begin
      tos_q <= op_inv ? ~tos_raw : tos_raw;
      nos_q <= nos_d;
    end
  end

  assign tos = tos_q;
  assign nos = nos_q;

  // R2
  swap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SWAP && !op_inv) |=> tos_q == $past(nos_q) && nos_q == $past(tos_q));
  // R3
  dup_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DUP && !op_inv) |=> tos_q == $past(tos_q) && nos_q == $past(tos_q));
  // R6
  lits_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_LITS && !op_inv) |=> tos_q == WIDTH'($past(lit5)) && nos_q == $past(tos_q));
  // R13
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(tos_q) && $stable(nos_q));
  // R8
  inv_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_NOP && op_inv) |=> tos_q == ~$past(tos_q));
endmodule

// File: rtl/stk_param_stack.sv
module stk_param_stack
  import stk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             op_inv,
  input  logic [4:0]       lit5,
  input  logic [WIDTH-1:0] lit_word,
  input  logic [WIDTH-1:0] alu_result,
  output logic [WIDTH-1:0] tos,
  output logic [WIDTH-1:0] nos,
  output logic [PW-1:0]    sp,
  output logic             ovf,
  output logic             unf
);
  logic             push_req, pop_req, mem_wr_en;
  logic [WIDTH-1:0] push_data, fill_data, mem_rd_data;
  logic [AW-1:0]    mem_wr_addr, mem_rd_addr;

  stk_reg_shuffle #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_inv(op_inv),
    .lit5(lit5), .lit_word(lit_word), .alu_result(alu_result), .fill_data(fill_data),
    .push_req(push_req), .pop_req(pop_req), .push_data(push_data), .tos(tos), .nos(nos)
  );

  stk_ptr_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_rd_addr(mem_rd_addr), .fill_data(fill_data), .sp(sp), .ovf(ovf), .unf(unf)
  );

  stk_spill_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(push_data),
    .rd_addr(mem_rd_addr), .rd_data(mem_rd_data)
  );

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_LAST_DEFINED) |=> $stable(tos) && $stable(nos) && $stable(sp));
  // R10
  alu_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ALU && !op_inv) |=> tos == $past(alu_result) && $stable(nos) && $stable(sp));
  // R4
  over_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_OVER && !op_inv) |=> tos == $past(nos) && nos == $past(tos));
endmodule

// File: tb/stk_param_stack_tb.sv
module stk_param_stack_tb;
  localparam int WIDTH = 16;
  localparam int DEPTH = 64;
  localparam int PW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic op_valid, op_inv;
  logic [3:0] op_code;
  logic [4:0] lit5;
  logic [WIDTH-1:0] lit_word, alu_result, tos, nos;
  logic [PW-1:0] sp;
  logic ovf, unf;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [WIDTH-1:0] m_mem [DEPTH];
  logic [WIDTH-1:0] m_tos, m_nos;
  int m_sp;
  logic m_ovf, m_unf;

  always #10 clk = ~clk;

  stk_param_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_inv(op_inv),
    .lit5(lit5), .lit_word(lit_word), .alu_result(alu_result),
    .tos(tos), .nos(nos), .sp(sp), .ovf(ovf), .unf(unf)
  );

  function automatic string req_of(input logic v, input logic [3:0] c, input logic inv);
    if (!v) return "R13";
    if (c > 4'd8) return "R9";
    if (inv) return "R8";
    case (c)
      4'd0: return "R8";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic m_push(input logic [WIDTH-1:0] d);
    if (m_sp == DEPTH) m_ovf = 1'b1;
    else begin m_mem[m_sp] = d; m_sp++; end
  endtask

  task automatic m_pop(output logic [WIDTH-1:0] d);
    if (m_sp == 0) begin m_unf = 1'b1; d = '0; end
    else begin m_sp--; d = m_mem[m_sp]; end
  endtask

  task automatic model_step(input logic v, input logic [3:0] c, input logic inv,
                            input logic [4:0] l5, input logic [WIDTH-1:0] lw,
                            input logic [WIDTH-1:0] ar);
    logic [WIDTH-1:0] t, n, f;
    if (!v || c > 4'd8) return;
    t = m_tos; n = m_nos;
    case (c)
      4'd1: begin t = m_nos; n = m_tos; end
      4'd2: begin m_push(m_nos); n = m_tos; end
      4'd3: begin m_push(m_nos); t = m_nos; n = m_tos; end
      4'd4: begin m_pop(f); t = m_nos; n = f; end
      4'd5: begin m_push(m_nos); t = WIDTH'(l5); n = m_tos; end
      4'd6: begin m_push(m_nos); t = lw; n = m_tos; end
      4'd7: t = ar;
      4'd8: begin m_pop(f); t = ar; n = f; end
      default: ;
    endcase
    m_tos = inv ? ~t : t;
    m_nos = n;
  endtask

  task automatic compare(input string req);
    logic [WIDTH*2+PW+1:0] act, exp;
    act = {tos, nos, sp, ovf, unf};
    exp = {m_tos, m_nos, PW'(m_sp), m_ovf, m_unf};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s tos/nos/sp/ovf/unf act=%h/%h/%0d/%b/%b exp=%h/%h/%0d/%b/%b",
               req, tos, nos, sp, ovf, unf, m_tos, m_nos, m_sp, m_ovf, m_unf);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic inv,
                      input logic [4:0] l5, input logic [WIDTH-1:0] lw,
                      input logic [WIDTH-1:0] ar, input string tag);
    @(negedge clk);
    op_valid = v; op_code = c; op_inv = inv; lit5 = l5; lit_word = lw; alu_result = ar;
    model_step(v, c, inv, l5, lw, ar);
    @(posedge clk);
    #5;
    compare(tag.len() > 0 ? tag : req_of(v, c, inv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    @(posedge clk); #5;
    rst = 1'b0;
    m_tos = '0; m_nos = '0; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    compare("R1");
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_inv = 1'b0;
    lit5 = '0; lit_word = '0; alu_result = '0;
    do_reset();

    // R12: pop from empty memory right after reset
    step(1, 4'd4, 0, 0, 0, 0, "R12");
    step(1, 4'd5, 0, 5'd31, 0, 0, "R6");
    step(1, 4'd6, 0, 0, 16'hBEEF, 0, "R7");
    step(1, 4'd3, 0, 0, 0, 0, "R4");
    step(1, 4'd1, 0, 0, 0, 0, "R2");
    step(1, 4'd2, 0, 0, 0, 0, "R3");
    step(1, 4'd7, 0, 0, 0, 16'h1234, "R10");
    step(1, 4'd8, 0, 0, 0, 16'h5678, "R10");
    step(1, 4'd0, 1, 0, 0, 0, "R8");
    step(1, 4'd12, 1, 0, 0, 0, "R9");
    step(0, 4'd5, 1, 5'd9, 0, 0, "R13");

    // R11: fill beyond capacity, then drain past empty (R5, R12)
    do_reset();
    for (int i = 0; i < DEPTH + 4; i++) step(1, 4'd6, 0, 0, 16'(i * 37 + 1), 0, "R11");
    for (int i = 0; i < DEPTH + 4; i++) step(1, 4'd4, 0, 0, 0, 0, "R5");

    // R9: reserved codes with complement bit
    for (int c = 9; c < 16; c++) step(1, 4'(c), 1, 5'd3, 16'hFFFF, 16'hAAAA, "R9");

    // random mix
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 9) != 0), c, ($urandom_range(0, 3) == 0),
           5'($urandom), 16'($urandom), 16'($urandom), "");
      if (i % 1000 == 999) do_reset();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule